// File: doc/BRIEF.md
# Three-Port Parallel I/O Register File

This block is a byte-wide register file of sixteen locations that sits on a processor bus. Through it the processor drives three seven-pin peripheral ports. Each port owns five locations. A data latch holds the levels to drive. A direction register marks each pin as driven (bit set) or sensed (bit clear). A transmit buffer holds a byte for a serial engine. A receive buffer is filled by that engine. A serial-control register holds that engine's settings. Location 0 holds a fixed identity byte. It combines a region code, a boot-ROM-present flag in bit 0 and an expansion-absent flag in bit 5.

Reading a port's data location merges two sources. Each pin marked as driven returns its latch bit, and each sensed pin returns its live input. Bit 7 has no pin, so it always returns the latch. Pins of a port that is built as unconnected read as all ones.

Each port also has a one-cycle strobe that tells the peripheral side to sample new drive levels. The strobe fires after every data write. After a direction write it fires only when the stored value actually changes. The serial shifting engine itself is outside this block, so the receive buffers keep their reset value. Reads are combinational from the address; writes take effect at the clock edge.

Top module: `io3_regfile`

## Requirements
- R1: After reset, location 0 reads REGION_BITS | (EXP_ABSENT<<5) | BOOT_ROM (0xA0 with the defaults). Transmit buffers at 0x7 and 0xA read 0xFF and the one at 0xD reads 0xFB. Direction registers (0x4–0x6), serial-control registers (0x9, 0xC, 0xF) and receive buffers (0x8, 0xB, 0xE) read 0x00.
- R2: A write to a data location (0x1 for port A, 0x2 for B, 0x3 for C) stores the byte. From the next cycle, bits 6:0 appear on that port's pin_out.
- R3: A read of a data location returns (latch & m) | (pins & ~m), where m = 0x80 | that port's direction register.
- R4: Bit 7 of a data read always equals bit 7 of the latch, whatever the direction register and pins hold.
- R5: A write to a data location raises that port's pin_stb for exactly the next cycle, even when the value is unchanged.
- R6: A write to a direction location (0x4 for A, 0x5 for B, 0x6 for C) stores the byte and drives bits 6:0 onto pin_oe. It raises pin_stb for the next cycle only if the new byte differs from the stored byte. An equal write leaves pin_stb low.
- R7: A write to a serial-control location keeps bits 7:3 only, so bits 2:0 always read back as 0.
- R8: A write to a transmit location stores all eight bits and changes no other location.
- R9: Writes to locations 0x0, 0x8, 0xB and 0xE are ignored. They leave the read value, pin_out, pin_oe and pin_stb unchanged.
- R10: A port whose bit in PORT_LINKED is 0 reads its sensed pins as 1 regardless of pin_in. With the default 3'b011, port C is the unconnected one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write enable for the addressed location |
| bus_addr | input | 4 | Location address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed location |
| pin_in | input | 3x7 | Live pin levels, one row per port |
| pin_out | output | 3x7 | Drive levels from the data latches |
| pin_oe | output | 3x7 | Per-pin drive enables from the direction registers |
| pin_stb | output | 3 | One-cycle update strobe per port |

## Verification
A data write and a direction write can reach the same port on consecutive cycles. The strobe raised by the first write then overlaps the decision whether the second write strobes at all. The bench provokes this by writing data and then, right after, a direction byte that is first equal to and then different from the stored one. It judges that the strobe is high for exactly the cycles the rules predict, and that pin_oe takes the new value in the same cycle as the strobe. It also changes pin levels between reads while direction values are swept, and judges every merged read against a value computed from the mask formula.

// File: rtl/io3_pkg.sv
package io3_pkg;
   localparam int NPORT  = 3;
   localparam int ADDR_W = 4;
   localparam int BYTE_W = 8;

   // location map: per-port offsets; the serial trio of port p starts at 7+3p
   function automatic logic [ADDR_W-1:0] loc_data(input int p);
      return ADDR_W'(1 + p);
   endfunction
   function automatic logic [ADDR_W-1:0] loc_dir(input int p);
      return ADDR_W'(4 + p);
   endfunction
   function automatic logic [ADDR_W-1:0] loc_tx(input int p);
      return ADDR_W'(7 + 3 * p);
   endfunction
   function automatic logic [ADDR_W-1:0] loc_rx(input int p);
      return ADDR_W'(8 + 3 * p);
   endfunction
   function automatic logic [ADDR_W-1:0] loc_scl(input int p);
      return ADDR_W'(9 + 3 * p);
   endfunction
endpackage

// File: rtl/io3_port_slice.sv
module io3_port_slice #(
   parameter int            PIN_W   = 7,
   parameter logic [PIN_W:0] TX_INIT = '1,
   parameter bit            LINKED  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_data,
   input  logic             sel_dir,
   input  logic             sel_tx,
   input  logic             sel_scl,
   input  logic [PIN_W:0]   wdata,
   input  logic [PIN_W-1:0] pins,
   output logic [PIN_W:0]   data_rd,
   output logic [PIN_W:0]   dir_q,
   output logic [PIN_W:0]   tx_q,
   output logic [PIN_W:0]   scl_q,
   output logic [PIN_W-1:0] drv,
   output logic [PIN_W-1:0] oe,
   output logic             stb
);
   localparam int             BYTE_W   = PIN_W + 1;
   localparam logic [PIN_W:0] SCL_KEEP = ~BYTE_W'(7);

   logic [PIN_W:0]   latch_q;
   logic [PIN_W-1:0] pins_eff;
   logic [PIN_W:0]   rd_mask;

   generate
      if (LINKED) begin : g_linked
         assign pins_eff = pins;
      end else begin : g_open
         assign pins_eff = '1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
         tx_q    <= TX_INIT;
         scl_q   <= '0;
         stb     <= 1'b0;
      end else begin
         stb <= sel_data | (sel_dir && (wdata != dir_q));
         if (sel_data) latch_q <= wdata;
         if (sel_dir)  dir_q   <= wdata;
         if (sel_tx)   tx_q    <= wdata;
         if (sel_scl)  scl_q   <= wdata & SCL_KEEP;
      end
   end

   assign rd_mask = {1'b1, dir_q[PIN_W-1:0]};
   assign data_rd = (latch_q & rd_mask) | ({1'b0, pins_eff} & ~rd_mask);
   assign drv     = latch_q[PIN_W-1:0];
   assign oe      = dir_q[PIN_W-1:0];
endmodule

// File: rtl/io3_regfile.sv
module io3_regfile #(
   parameter int         PIN_W       = 7,
   parameter logic [7:0] REGION_BITS = 8'h80,
   parameter bit         BOOT_ROM    = 1'b0,
   parameter bit         EXP_ABSENT  = 1'b1,
   parameter logic [2:0] PORT_LINKED = 3'b011
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic [3:0]            bus_addr,
   input  logic [PIN_W:0]        bus_wdata,
   output logic [PIN_W:0]        bus_rdata,
   input  logic [2:0][PIN_W-1:0] pin_in,
   output logic [2:0][PIN_W-1:0] pin_out,
   output logic [2:0][PIN_W-1:0] pin_oe,
   output logic [2:0]            pin_stb
);
   import io3_pkg::*;

   localparam int         BYTE_W   = PIN_W + 1;
   localparam logic [7:0] IDENTITY = REGION_BITS | {2'b00, EXP_ABSENT, 4'b0000, BOOT_ROM};

   generate
      if (PIN_W != 7) begin : g_bad_width
         $error("io3_regfile: PIN_W must be 7, bit 7 is the latch-only bit");
      end
      if (REGION_BITS[5] || REGION_BITS[0]) begin : g_bad_region
         $error("io3_regfile: REGION_BITS must leave bits 5 and 0 clear");
      end
   endgenerate

   logic [NPORT-1:0][BYTE_W-1:0] data_rd, dir_q, tx_q, scl_q;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      localparam logic [BYTE_W-1:0] TX_RST = (p == 2) ? BYTE_W'(8'hFB) : '1;
      io3_port_slice #(
         .PIN_W  (PIN_W),
         .TX_INIT(TX_RST),
         .LINKED (PORT_LINKED[p])
      ) i_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .sel_data(bus_wr && (bus_addr == loc_data(p))),
         .sel_dir (bus_wr && (bus_addr == loc_dir(p))),
         .sel_tx  (bus_wr && (bus_addr == loc_tx(p))),
         .sel_scl (bus_wr && (bus_addr == loc_scl(p))),
         .wdata   (bus_wdata),
         .pins    (pin_in[p]),
         .data_rd (data_rd[p]),
         .dir_q   (dir_q[p]),
         .tx_q    (tx_q[p]),
         .scl_q   (scl_q[p]),
         .drv     (pin_out[p]),
         .oe      (pin_oe[p]),
         .stb     (pin_stb[p])
      );
   end

   always_comb begin
      bus_rdata = IDENTITY[BYTE_W-1:0];
      for (int p = 0; p < NPORT; p++) begin
         if (bus_addr == loc_data(p)) bus_rdata = data_rd[p];
         if (bus_addr == loc_dir(p))  bus_rdata = dir_q[p];
         if (bus_addr == loc_tx(p))   bus_rdata = tx_q[p];
         if (bus_addr == loc_rx(p))   bus_rdata = '0;
         if (bus_addr == loc_scl(p))  bus_rdata = scl_q[p];
      end
   end
endmodule

// File: rtl/io3_checker.sv
module io3_checker #(
   parameter int PIN_W = 7
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_wr,
   input logic [3:0]            bus_addr,
   input logic [PIN_W:0]        bus_wdata,
   input logic [PIN_W:0]        bus_rdata,
   input logic [2:0][PIN_W-1:0] pin_out,
   input logic [2:0][PIN_W-1:0] pin_oe,
   input logic [2:0]            pin_stb
);
   for (genvar p = 0; p < 3; p++) begin : g_chk
      a_r5_stb_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
         pin_stb[p] |-> $past(bus_wr) &&
            (($past(bus_addr) == 4'(1 + p)) || ($past(bus_addr) == 4'(4 + p))));

      a_r5_data_strobes: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == 4'(1 + p)) |=> pin_stb[p]);

      a_r2_drive_follows: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == 4'(1 + p)) |=> (pin_out[p] == $past(bus_wdata[PIN_W-1:0])));

      a_r6_oe_follows: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == 4'(4 + p)) |=> (pin_oe[p] == $past(bus_wdata[PIN_W-1:0])));

      a_r6_change_strobes: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == 4'(4 + p) && bus_wdata[PIN_W-1:0] != pin_oe[p]) |=> pin_stb[p]);

      a_r7_scl_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_addr == 4'(9 + 3 * p)) |-> (bus_rdata[2:0] == 3'b000));

      a_r9_rx_constant: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_addr == 4'(8 + 3 * p)) |-> (bus_rdata == '0));
   end
endmodule

bind io3_regfile io3_checker #(.PIN_W(7)) i_io3_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe),
   .pin_stb  (pin_stb)
);

// File: tb/test_io3_regfile.sv
module test_io3_regfile;
   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bus_wr = 1'b0;
   logic [3:0]       bus_addr = '0;
   logic [7:0]       bus_wdata = '0;
   logic [7:0]       bus_rdata;
   logic [2:0][6:0]  pin_in = '0;
   logic [2:0][6:0]  pin_out;
   logic [2:0][6:0]  pin_oe;
   logic [2:0]       pin_stb;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   logic [7:0] dir_m [3];

   always #4 clk = ~clk;

   io3_regfile i_io3_regfile (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_stb(pin_stb)
   );

   function automatic logic [7:0] merged(input logic [7:0] l, input logic [7:0] d,
                                         input logic [6:0] pins);
      logic [7:0] m;
      m = 8'h80 | d;
      return (l & m) | ({1'b0, pins} & ~m);
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic idle;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int p = 0; p < 3; p++) dir_m[p] = 8'h00;
      pin_in[0] = 7'h55; pin_in[1] = 7'h2A; pin_in[2] = 7'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();

      // R1 reset map; R10 port C unconnected reads 0x7F
      for (int a = 0; a < 16; a++) begin
         logic [7:0] e;
         case (a)
            0: e = 8'hA0;
            1: e = 8'h55;
            2: e = 8'h2A;
            3: e = 8'h7F;
            7, 10: e = 8'hFF;
            13: e = 8'hFB;
            default: e = 8'h00;
         endcase
         rd(4'(a), e, "R1 reset value");
      end
      chk("R1 reset stb", {5'b0, pin_stb}, 8'h00);

      // R3/R4 near-exhaustive merge sweep on ports A and B
      for (int p = 0; p < 2; p++) begin
         logic [7:0] lat;
         lat = (p == 0) ? 8'hC3 : 8'h3C;
         wr(4'(1 + p), lat);
         for (int d = 0; d < 256; d += 5) begin
            wr(4'(4 + p), 8'(d));
            dir_m[p] = 8'(d);
            for (int k = 0; k < 128; k += 11) begin
               pin_in[p] = 7'(k);
               rd(4'(1 + p), merged(lat, 8'(d), 7'(k)), "R3 merged read");
            end
         end
      end

      // R4 bit 7 taken from latch whatever the pins
      wr(4'h5, 8'h00); dir_m[1] = 8'h00;
      pin_in[1] = 7'h7F;
      wr(4'h2, 8'h80);
      rd(4'h2, 8'hFF, "R4 latch bit7 set");
      wr(4'h2, 8'h00);
      rd(4'h2, 8'h7F, "R4 latch bit7 clear");

      // R10 port C ignores pin_in
      pin_in[2] = 7'h00;
      rd(4'h3, 8'h7F, "R10 open port low pins");
      pin_in[2] = 7'h15;
      wr(4'h6, 8'h0F); dir_m[2] = 8'h0F;
      wr(4'h3, 8'h05);
      rd(4'h3, 8'h75, "R10 open port mixed");

      // R2 and R5: data write drives pins and strobes once, even if unchanged
      wr(4'h1, 8'h5A);
      chk("R2 pin_out A", {1'b0, pin_out[0]}, 8'h5A);
      chk("R5 stb after data write", {7'b0, pin_stb[0]}, 8'h01);
      idle();
      chk("R5 stb drops", {7'b0, pin_stb[0]}, 8'h00);
      wr(4'h1, 8'h5A);
      chk("R5 stb on same value", {7'b0, pin_stb[0]}, 8'h01);

      // R6 back-to-back: data write then direction writes equal / differing
      for (int p = 0; p < 3; p++) begin
         logic [7:0] nv;
         wr(4'(1 + p), 8'h11);
         chk("R5 stb before dir", {7'b0, pin_stb[p]}, 8'h01);
         wr(4'(4 + p), dir_m[p]);
         chk("R6 equal dir no stb", {7'b0, pin_stb[p]}, 8'h00);
         nv = dir_m[p] ^ 8'h80;
         wr(4'(4 + p), nv);
         chk("R6 bit7-only change strobes", {7'b0, pin_stb[p]}, 8'h01);
         dir_m[p] = nv;
         nv = dir_m[p] ^ 8'h24;
         wr(4'(4 + p), nv);
         chk("R6 changed dir strobes", {7'b0, pin_stb[p]}, 8'h01);
         chk("R6 pin_oe same cycle", {1'b0, pin_oe[p]}, {1'b0, nv[6:0]});
         dir_m[p] = nv;
         rd(4'(4 + p), nv, "R6 dir readback");
         idle();
         chk("R6 stb one cycle", {7'b0, pin_stb[p]}, 8'h00);
      end

      // R7 serial control low bits clear; R8 transmit buffers
      for (int p = 0; p < 3; p++) begin
         wr(4'(9 + 3 * p), 8'hFF);
         rd(4'(9 + 3 * p), 8'hF8, "R7 scl masked");
         wr(4'(9 + 3 * p), 8'h0D);
         rd(4'(9 + 3 * p), 8'h08, "R7 scl masked low");
      end
      wr(4'h7, 8'h96);
      rd(4'h7, 8'h96, "R8 tx A");
      rd(4'hA, 8'hFF, "R8 tx B untouched");
      rd(4'hD, 8'hFB, "R8 tx C untouched");
      wr(4'hD, 8'h03);
      rd(4'hD, 8'h03, "R8 tx C");
      rd(4'h7, 8'h96, "R8 tx A untouched");

      // R9 read-only locations
      begin
         logic [2:0][6:0] po, pe;
         idle();
         po = pin_out; pe = pin_oe;
         for (int i = 0; i < 4; i++) begin
            logic [3:0] a;
            a = (i == 0) ? 4'h0 : 4'(5 + 3 * i);
            wr(a, 8'h5F);
            rd(a, (i == 0) ? 8'hA0 : 8'h00, "R9 read-only value");
            chk("R9 no stb", {5'b0, pin_stb}, 8'h00);
            chk("R9 pin_out held", {1'b0, pin_out[0] ^ po[0] | pin_out[1] ^ po[1] | pin_out[2] ^ po[2]}, 8'h00);
            chk("R9 pin_oe held", {1'b0, pin_oe[0] ^ pe[0] | pin_oe[1] ^ pe[1] | pin_oe[2] ^ pe[2]}, 8'h00);
         end
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule